// File: doc/BRIEF.md
# Hybrid Dynamic/Static Branch Predictor

This block sits beside instruction fetch and gives a direction and a target for every branch that fetch presents. The first source is a small direct-mapped table of recently retired branches, selected by the low bits of the branch's linear address and confirmed by a tag. Each table entry holds a 2-bit saturating direction counter and a target address.

When the table has no matching entry, a conditional branch is predicted from the sign of its displacement. A negative displacement points backward, as a loop-closing branch does, and is predicted taken. A zero or positive displacement is predicted not taken. Returns take their target from a 16-deep return-address stack, and every near call pushes its fall-through address onto that stack. Far transfers are never predicted.

The table changes only through the retire-time update port. A flush empties the table and the stack at the same time. Predictions are combinational from the lookup inputs. Pushes, pops and table writes take effect at the next rising clock edge.

Top module: `hyb_bpred`

## Requirements
- R1: The branch kind is encoded as 0 conditional, 1 near direct call, 2 return, 3 indirect, and 4 to 7 far (far call or software interrupt). For kinds 0, 1 and 3, a valid entry whose tag (address bits above bit 3) matches at index address[3:0] gives predHit=1 and predTaken equal to the counter's upper bit. predTarget is then the stored target when taken and lookupFall when not taken.
- R2: A conditional branch with no matching entry gives predHit=0. It is predicted taken with target lookupAddr+lookupDisp when lookupDisp is negative, and not taken with target lookupFall when lookupDisp is zero or positive.
- R3: A near direct call with no matching entry is predicted taken with target lookupAddr+lookupDisp and predHit=0.
- R4: An indirect branch with no matching entry is predicted not taken with target lookupFall.
- R5: Kinds 4 to 7 always give predTaken=0, predHit=0 and predTarget=lookupFall, even when a matching table entry exists, and they leave the return stack unchanged.
- R6: A return lookup gives predTaken=1 and predHit=0. Its target is the top of the return stack, and that entry is popped at the next clock edge.
- R7: Every valid lookup of kind 1 pushes lookupFall onto the return stack, whether or not it hits in the table.
- R8: The return stack holds 16 entries. A push onto a full stack overwrites the oldest entry. A return on an empty stack predicts lookupFall and pops nothing.
- R9: An update that misses allocates the entry at updAddr[3:0] with the new tag and target updTarget. Its counter starts at 2 (weakly taken) when updTaken=1 and at 1 (weakly not taken) otherwise.
- R10: An update that hits moves the counter one step toward taken or not taken, saturating at 3 and 0. The stored target is replaced by updTarget only when updTaken=1.
- R11: Lookups never alter table contents. When lookupValid=0, the outputs are predTaken=0, predHit=0 and predTarget=lookupFall.
- R12: A flush invalidates every table entry and empties the return stack. In the same cycle it overrides any update and any push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A branch is presented for prediction |
| lookupAddr | input | ADDR_W | Linear address of the branch |
| lookupKind | input | 3 | Branch kind code |
| lookupDisp | input | ADDR_W | Signed displacement of a direct branch |
| lookupFall | input | ADDR_W | Address of the next sequential instruction |
| updValid | input | 1 | A retired branch updates the table |
| updAddr | input | ADDR_W | Address of the retired branch |
| updTarget | input | ADDR_W | Resolved target of the retired branch |
| updTaken | input | 1 | Resolved direction of the retired branch |
| flush | input | 1 | Clear table and return stack |
| predTaken | output | 1 | Predicted direction |
| predTarget | output | ADDR_W | Predicted next fetch address |
| predHit | output | 1 | Prediction came from the table |

## Verification
The hardest state to reach is a return stack that has wrapped, where the seventeenth call has silently replaced the oldest entry. The stimulus reaches it with a run of seventeen calls to distinct fall-through addresses, followed by seventeen returns. The first sixteen returns must come back newest first, and the last must see an empty stack and fall through. Counter saturation and the retained target after a not-taken update need several back-to-back updates to one address before a lookup, so the directed part drives those sequences. A long random phase with a narrow address range then mixes same-cycle updates, lookups and rare flushes against the behavioural model.

// File: rtl/hyb_bpred_pkg.sv
package hyb_bpred_pkg;

  localparam logic [2:0] KIND_COND  = 3'd0;
  localparam logic [2:0] KIND_CALL  = 3'd1;
  localparam logic [2:0] KIND_RET   = 3'd2;
  localparam logic [2:0] KIND_INDIR = 3'd3;

  typedef enum logic [1:0] {
    SEL_FALL,
    SEL_TABLE,
    SEL_STATIC,
    SEL_STACK
  } predSel_e;

  typedef struct packed {
    logic     tblClear;
    logic     tblWrite;
    logic     tblAlloc;
    logic     stkPush;
    logic     stkPop;
    logic     stkClear;
    predSel_e sel;
    logic     taken;
  } bpStrobe_t;

endpackage

// File: rtl/hyb_bpred_ctrl.sv
module hyb_bpred_ctrl
  import hyb_bpred_pkg::*;
(
  input  logic       lookupValid,
  input  logic [2:0] lookupKind,
  input  logic       dispNeg,
  input  logic       updValid,
  input  logic       flush,
  input  logic       lookHit,
  input  logic       lookCtrMsb,
  input  logic       updHit,
  input  logic       stkEmpty,
  output bpStrobe_t  strobe,
  output logic       predHit
);

  logic tableKind;
  assign tableKind = (lookupKind == KIND_COND) || (lookupKind == KIND_CALL) ||
                     (lookupKind == KIND_INDIR);

  always_comb begin
    strobe       = '0;
    strobe.sel   = SEL_FALL;
    strobe.taken = 1'b0;
    predHit      = 1'b0;
    if (lookupValid) begin
      if (tableKind && lookHit) begin
        predHit      = 1'b1;
        strobe.taken = lookCtrMsb;
        strobe.sel   = lookCtrMsb ? SEL_TABLE : SEL_FALL;
      end else begin
        case (lookupKind)
          KIND_COND: begin
            strobe.taken = dispNeg;
            strobe.sel   = dispNeg ? SEL_STATIC : SEL_FALL;
          end
          KIND_CALL: begin
            strobe.taken = 1'b1;
            strobe.sel   = SEL_STATIC;
          end
          KIND_RET: begin
            strobe.taken = 1'b1;
            strobe.sel   = SEL_STACK;
          end
          default: begin
            strobe.taken = 1'b0;
            strobe.sel   = SEL_FALL;
          end
        endcase
      end
    end
    strobe.tblClear = flush;
    strobe.stkClear = flush;
    strobe.tblWrite = updValid && !flush;
    strobe.tblAlloc = updValid && !flush && !updHit;
    strobe.stkPush  = lookupValid && (lookupKind == KIND_CALL) && !flush;
    strobe.stkPop   = lookupValid && (lookupKind == KIND_RET) && !flush && !stkEmpty;
  end

endmodule

// File: rtl/hyb_bpred_dp.sv
module hyb_bpred_dp
  import hyb_bpred_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int STK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [ADDR_W-1:0] lookupDisp,
  input  logic [ADDR_W-1:0] lookupFall,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken,
  output logic              lookHit,
  output logic              lookCtrMsb,
  output logic              updHit,
  output logic              stkEmpty,
  output logic [ADDR_W-1:0] predTarget
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam int PTR_W   = $clog2(STK_DEPTH);
  localparam int CNT_W   = $clog2(STK_DEPTH + 1);

  logic              entValid [ENTRIES];
  logic [TAG_W-1:0]  entTag   [ENTRIES];
  logic [1:0]        entCtr   [ENTRIES];
  logic [ADDR_W-1:0] entTarget[ENTRIES];

  logic [IDX_W-1:0] lookIdx, updIdx;
  logic [TAG_W-1:0] lookTag, updTag;
  assign lookIdx = lookupAddr[IDX_W-1:0];
  assign lookTag = lookupAddr[ADDR_W-1:IDX_W];
  assign updIdx  = updAddr[IDX_W-1:0];
  assign updTag  = updAddr[ADDR_W-1:IDX_W];

  assign lookHit    = entValid[lookIdx] && (entTag[lookIdx] == lookTag);
  assign lookCtrMsb = entCtr[lookIdx][1];
  assign updHit     = entValid[updIdx] && (entTag[updIdx] == updTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        entValid[e]  <= 1'b0;
        entTag[e]    <= '0;
        entCtr[e]    <= 2'b00;
        entTarget[e] <= '0;
      end
    end else if (strobe.tblClear) begin
      for (int e = 0; e < ENTRIES; e++) entValid[e] <= 1'b0;
    end else if (strobe.tblWrite) begin
      entValid[updIdx] <= 1'b1;
      entTag[updIdx]   <= updTag;
      if (strobe.tblAlloc) entCtr[updIdx] <= updTaken ? 2'b10 : 2'b01;
      else if (updTaken && entCtr[updIdx] != 2'b11) entCtr[updIdx] <= entCtr[updIdx] + 2'b01;
      else if (!updTaken && entCtr[updIdx] != 2'b00) entCtr[updIdx] <= entCtr[updIdx] - 2'b01;
      if (strobe.tblAlloc || updTaken) entTarget[updIdx] <= updTarget;
    end
  end

  // Return stack: circular buffer, count saturates so a full push drops the oldest.
  logic [ADDR_W-1:0] stkMem[STK_DEPTH];
  logic [PTR_W-1:0]  stkPtr;
  logic [CNT_W-1:0]  stkCnt;
  logic [ADDR_W-1:0] stkTop;

  assign stkTop   = stkMem[stkPtr - PTR_W'(1)];
  assign stkEmpty = (stkCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STK_DEPTH; s++) stkMem[s] <= '0;
      stkPtr <= '0;
      stkCnt <= '0;
    end else if (strobe.stkClear) begin
      stkPtr <= '0;
      stkCnt <= '0;
    end else if (strobe.stkPush) begin
      stkMem[stkPtr] <= lookupFall;
      stkPtr         <= stkPtr + PTR_W'(1);
      if (stkCnt != CNT_W'(STK_DEPTH)) stkCnt <= stkCnt + CNT_W'(1);
    end else if (strobe.stkPop) begin
      stkPtr <= stkPtr - PTR_W'(1);
      stkCnt <= stkCnt - CNT_W'(1);
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_TABLE:  predTarget = entTarget[lookIdx];
      SEL_STATIC: predTarget = lookupAddr + lookupDisp;
      SEL_STACK:  predTarget = stkEmpty ? lookupFall : stkTop;
      default:    predTarget = lookupFall;
    endcase
  end

endmodule

// File: rtl/hyb_bpred.sv
module hyb_bpred
  import hyb_bpred_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int STK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic [2:0]        lookupKind,
  input  logic [ADDR_W-1:0] lookupDisp,
  input  logic [ADDR_W-1:0] lookupFall,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              updTaken,
  input  logic              flush,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predTarget,
  output logic              predHit
);

  bpStrobe_t strobe;
  logic lookHit, lookCtrMsb, updHit, stkEmpty;

  hyb_bpred_ctrl u_ctrl (
    .lookupValid(lookupValid),
    .lookupKind (lookupKind),
    .dispNeg    (lookupDisp[ADDR_W-1]),
    .updValid   (updValid),
    .flush      (flush),
    .lookHit    (lookHit),
    .lookCtrMsb (lookCtrMsb),
    .updHit     (updHit),
    .stkEmpty   (stkEmpty),
    .strobe     (strobe),
    .predHit    (predHit)
  );

  hyb_bpred_dp #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .STK_DEPTH(STK_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lookupAddr(lookupAddr),
    .lookupDisp(lookupDisp),
    .lookupFall(lookupFall),
    .updAddr   (updAddr),
    .updTarget (updTarget),
    .updTaken  (updTaken),
    .lookHit   (lookHit),
    .lookCtrMsb(lookCtrMsb),
    .updHit    (updHit),
    .stkEmpty  (stkEmpty),
    .predTarget(predTarget)
  );

  assign predTaken = strobe.taken;

endmodule

// File: rtl/hyb_bpred_chk.sv
module hyb_bpred_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [ADDR_W-1:0] lookupAddr,
  input logic [2:0]        lookupKind,
  input logic [ADDR_W-1:0] lookupDisp,
  input logic [ADDR_W-1:0] lookupFall,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic [ADDR_W-1:0] updTarget,
  input logic              updTaken,
  input logic              flush,
  input logic              predTaken,
  input logic [ADDR_W-1:0] predTarget,
  input logic              predHit
);

  a_r5_far_silent: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupKind >= 3'd4) |-> (!predTaken && !predHit && predTarget == lookupFall));

  a_r4_indirect_miss: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupKind == 3'd3 && !predHit) |-> (!predTaken && predTarget == lookupFall));

  a_r2_backward_taken: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupKind == 3'd0 && !predHit && lookupDisp[ADDR_W-1])
      |-> (predTaken && predTarget == lookupAddr + lookupDisp));

  a_r6_return_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupKind == 3'd2) |-> (predTaken && !predHit));

  a_r12_flush_empties_table: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !predHit);

  a_r8_empty_return_falls: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flush) && lookupValid && lookupKind == 3'd2) |-> (predTarget == lookupFall));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> (!predTaken && !predHit && predTarget == lookupFall));

endmodule

bind hyb_bpred hyb_bpred_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hyb_bpred_bench.sv
`timescale 1ns/1ps
module hyb_bpred_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic [2:0]  lookupKind = '0;
  logic [31:0] lookupDisp = '0;
  logic [31:0] lookupFall = '0;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic [31:0] updTarget = '0;
  logic        updTaken = 1'b0;
  logic        flush = 1'b0;
  logic        predTaken;
  logic [31:0] predTarget;
  logic        predHit;

  int nChecks = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  hyb_bpred u_hyb_bpred (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupKind(lookupKind), .lookupDisp(lookupDisp), .lookupFall(lookupFall),
    .updValid(updValid), .updAddr(updAddr), .updTarget(updTarget), .updTaken(updTaken),
    .flush(flush), .predTaken(predTaken), .predTarget(predTarget), .predHit(predHit)
  );

  // Behavioural reference state
  bit          mValid[16];
  logic [27:0] mTag[16];
  logic [1:0]  mCtr[16];
  logic [31:0] mTgt[16];
  logic [31:0] mStack[$];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [2:0] k, input logic [31:0] a,
                      input logic [31:0] d, input logic [31:0] f,
                      input logic uv, input logic [31:0] ua, input logic [31:0] ut,
                      input logic utk, input logic fl, input string tag);
    logic eTaken, eHit, hitM;
    logic [31:0] eTgt;
    int i, j;
    @(negedge clk);
    lookupValid = lv; lookupKind = k; lookupAddr = a; lookupDisp = d; lookupFall = f;
    updValid = uv; updAddr = ua; updTarget = ut; updTaken = utk; flush = fl;
    #1;
    i = int'(a[3:0]);
    hitM = mValid[i] && (mTag[i] == a[31:4]);
    eTaken = 1'b0; eHit = 1'b0; eTgt = f;
    if (lv) begin
      if ((k == 3'd0 || k == 3'd1 || k == 3'd3) && hitM) begin
        eHit = 1'b1; eTaken = mCtr[i][1]; eTgt = eTaken ? mTgt[i] : f;
      end else if (k == 3'd0) begin
        eTaken = d[31]; eTgt = eTaken ? a + d : f;
      end else if (k == 3'd1) begin
        eTaken = 1'b1; eTgt = a + d;
      end else if (k == 3'd2) begin
        eTaken = 1'b1; eTgt = (mStack.size() > 0) ? mStack[$] : f;
      end
    end
    chk(tag, "predTaken", {31'b0, predTaken}, {31'b0, eTaken});
    chk(tag, "predHit", {31'b0, predHit}, {31'b0, eHit});
    chk(tag, "predTarget", predTarget, eTgt);
    if (fl) begin
      for (int e = 0; e < 16; e++) mValid[e] = 1'b0;
      mStack.delete();
    end else begin
      if (uv) begin
        j = int'(ua[3:0]);
        if (mValid[j] && mTag[j] == ua[31:4]) begin
          if (utk && mCtr[j] != 2'b11) mCtr[j] = mCtr[j] + 2'b01;
          else if (!utk && mCtr[j] != 2'b00) mCtr[j] = mCtr[j] - 2'b01;
          if (utk) mTgt[j] = ut;
        end else begin
          mValid[j] = 1'b1; mTag[j] = ua[31:4]; mCtr[j] = utk ? 2'b10 : 2'b01; mTgt[j] = ut;
        end
      end
      if (lv && k == 3'd1) begin
        mStack.push_back(f);
        if (mStack.size() > 16) void'(mStack.pop_front());
      end else if (lv && k == 3'd2 && mStack.size() > 0) begin
        void'(mStack.pop_back());
      end
    end
  endtask

  task automatic look(input logic [2:0] k, input logic [31:0] a, input logic [31:0] d,
                      input logic [31:0] f, input string tag);
    step(1'b1, k, a, d, f, 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic upd(input logic [31:0] ua, input logic [31:0] ut, input logic utk, input string tag);
    step(1'b0, 3'd0, '0, '0, 32'h40, 1'b1, ua, ut, utk, 1'b0, tag);
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    logic [31:0] pA, pB, pC;
    pA = 32'h0000_1234; pB = 32'h0000_3008; pC = 32'h0000_7abc;
    for (int e = 0; e < 16; e++) mValid[e] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // Reset state and static conditional rule
    look(3'd0, pA, 32'd8, pA + 4, "R2");
    look(3'd0, pA, -32'sd16, pA + 4, "R2");
    look(3'd0, pA, 32'd0, pA + 4, "R2");
    // Call pushes, return pops, empty return falls through
    look(3'd1, 32'h2000, 32'h100, 32'h2004, "R3");
    look(3'd2, 32'h2200, 32'h0, 32'h2204, "R6");
    look(3'd2, 32'h2300, 32'h0, 32'h2304, "R8");
    look(3'd4, 32'h2400, 32'h10, 32'h2404, "R5");
    look(3'd1, 32'h2500, 32'h40, 32'h2504, "R7");
    look(3'd6, 32'h2600, 32'h10, 32'h2604, "R5");
    look(3'd2, 32'h2700, 32'h0, 32'h2704, "R7");
    look(3'd3, pB, 32'h20, pB + 4, "R4");
    // Allocation taken, then table hit, far ignores it, lookups do not change it
    upd(pA, 32'h5000, 1'b1, "R9");
    look(3'd0, pA, 32'd8, pA + 4, "R1");
    look(3'd5, pA, 32'd8, pA + 4, "R5");
    look(3'd1, pA, 32'h40, pA + 4, "R1");
    look(3'd2, pA, 32'h0, pA + 4, "R6");
    look(3'd0, pA, 32'd8, pA + 4, "R11");
    // Counter walk and target retention
    upd(pA, 32'h6000, 1'b0, "R10");
    upd(pA, 32'h6000, 1'b0, "R10");
    upd(pA, 32'h6000, 1'b0, "R10");
    look(3'd0, pA, -32'sd8, pA + 4, "R10");
    upd(pA, 32'h7000, 1'b1, "R10");
    look(3'd0, pA, -32'sd8, pA + 4, "R10");
    upd(pA, 32'h7100, 1'b1, "R10");
    look(3'd3, pA, 32'd0, pA + 4, "R10");
    upd(pA, 32'h7200, 1'b1, "R10");
    upd(pA, 32'h7300, 1'b1, "R10");
    upd(pA, 32'h7400, 1'b0, "R10");
    look(3'd0, pA, 32'd4, pA + 4, "R10");
    // Not-taken allocation
    upd(pB, 32'h9000, 1'b0, "R9");
    look(3'd3, pB, 32'd0, pB + 4, "R9");
    // Stack wrap: 17 pushes then 17 pops
    for (int n = 0; n < 17; n++) look(3'd1, 32'h8000 + n * 64, 32'h10, 32'h100 + n * 16, "R8");
    for (int n = 0; n < 17; n++) look(3'd2, 32'h9000 + n * 64, 32'h0, 32'hA00 + n * 4, "R8");
    // Flush overriding a same-cycle update and push
    look(3'd1, 32'hB000, 32'h10, 32'hB004, "R7");
    step(1'b1, 3'd1, 32'hB100, 32'h10, 32'hB104, 1'b1, pC, 32'hC000, 1'b1, 1'b1, "R12");
    look(3'd2, 32'hB200, 32'h0, 32'hB204, "R12");
    look(3'd0, pC, 32'd4, pC + 4, "R12");
    look(3'd0, pA, 32'd4, pA + 4, "R12");
    look(3'd3, pB, 32'd0, pB + 4, "R12");

    // Random mixed traffic in a narrow address range
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rd, ua;
      ra = 32'h0001_0000 + (($urandom % 3) << 4) + ($urandom % 16);
      ua = 32'h0001_0000 + (($urandom % 3) << 4) + ($urandom % 16);
      rd = 32'($urandom % 64) - 32'd32;
      step(($urandom % 5) != 0, 3'($urandom % 6), ra, rd, ra + 4,
           ($urandom % 3) == 0, ua, $urandom, 1'($urandom), ($urandom % 100) == 0, "R11");
    end

    step(1'b0, 3'd0, '0, '0, 32'h44, 1'b0, '0, '0, 1'b0, 1'b0, "R11");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule